// File: doc/BRIEF.md
# Cell Start Window Checker

This block turns an external cell-start pulse into an internal cell-start reference. The reference is delayed by a programmable number of clocks. The internal pulse then opens an acceptance window exactly eight clocks long. Every input port has its own start-of-cell strobe. The block checks that each port's strobe falls inside that window, and only once.

At the last clock of each window the block publishes two per-port flags. One marks ports that started a cell in the window. The other marks ports that stayed silent. A silent port is not treated as a fault.

A strobe seen while the window is shut sets that port's error flag, and so does a second strobe within one window. The error flag is sticky until a write-one-to-clear input clears it. A new external pulse that arrives while a delay is still counting restarts the delay.

Top module: `cell_window_chk`

## Requirements
- R1: With an offset N greater than zero, `int_start` is a single-cycle pulse that rises N clock cycles after the cycle in which `int_start` would rise for offset zero.
- R2: With an offset of zero, `int_start` is high in the cycle right after the cycle in which `ext_start` was high.
- R3: An `ext_start` pulse seen while a delay is still counting reloads the count from `offset`, and the earlier pulse produces no `int_start` of its own.
- R4: `win_open` is high in the cycle in which `int_start` is high and in the seven cycles that follow, eight cycles in all, and is low otherwise.
- R5: A port that strobes `soc_in` exactly once while `win_open` is high has its bit of `arrived` set and its bit of `idle` clear from the cycle after the window's last cycle, and its `err` bit is not set.
- R6: A `soc_in` strobe sampled while `win_open` is low sets that port's `err` bit on the next cycle.
- R7: A second `soc_in` strobe on the same port within one window sets that port's `err` bit, and the port still reports as arrived.
- R8: A port with no strobe during a window has its `idle` bit set and its `arrived` bit clear after the window closes, and its `err` bit is left unchanged.
- R9: An `err` bit stays set until a cycle in which the matching `err_clr` bit is 1; when a new error and a clear hit the same bit in the same cycle, the bit stays set.
- R10: After reset, `int_start`, `win_open`, `arrived`, `idle` and `err` are all zero. `arrived` and `idle` change only at a window close and hold their values between closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_start | input | 1 | External cell-start pulse |
| offset | input | OFFW | Delay from external to internal cell start, in clocks |
| soc_in | input | NPORTS | Per-port start-of-cell strobe |
| err_clr | input | NPORTS | Write-one-to-clear for `err` |
| int_start | output | 1 | Internal cell-start pulse |
| win_open | output | 1 | Acceptance window active |
| arrived | output | NPORTS | Ports that started a cell in the last window |
| idle | output | NPORTS | Ports that were silent in the last window |
| err | output | NPORTS | Sticky misalignment error per port |

## Verification
A wrong delay count shows up at `int_start` and `win_open` directly. It appears within the programmed offset plus one cycle. A bad window counter or a bad per-port seen state stays hidden until the window closes. It then appears one cycle after the eighth window cycle, either as wrong `arrived` and `idle` bits or as an error flag raised in the wrong place. Loss of stickiness or a wrong clear priority shows on `err` in the cycle that follows the clear.

// File: rtl/cell_window_chk.sv
module cell_window_chk #(
  parameter int NPORTS = 8,
  parameter int OFFW   = 8,
  parameter int WIN    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_start,
  input  logic [OFFW-1:0]   offset,
  input  logic [NPORTS-1:0] soc_in,
  input  logic [NPORTS-1:0] err_clr,
  output logic              int_start,
  output logic              win_open,
  output logic [NPORTS-1:0] arrived,
  output logic [NPORTS-1:0] idle,
  output logic [NPORTS-1:0] err
);
  localparam int WCW = $clog2(WIN + 1);

  logic [OFFW-1:0]   dly;
  logic [WCW-1:0]    wcnt;
  logic [NPORTS-1:0] seen;
  logic              fire, close;
  logic [NPORTS-1:0] bad, got;

  assign fire     = ext_start ? (offset == '0) : (dly == OFFW'(1));
  assign win_open = (wcnt != '0);
  assign close    = win_open && (wcnt == WCW'(1)) && !fire;
  assign bad      = soc_in & ~({NPORTS{win_open}} & ~seen);
  assign got      = seen | soc_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dly       <= '0;
      wcnt      <= '0;
      int_start <= 1'b0;
      seen      <= '0;
      arrived   <= '0;
      idle      <= '0;
      err       <= '0;
    end else begin
      if (ext_start)          dly <= offset;
      else if (dly != '0)     dly <= dly - 1'b1;
      int_start <= fire;
      if (fire)               wcnt <= WCW'(WIN);
      else if (win_open)      wcnt <= wcnt - 1'b1;
      if (fire || close)      seen <= '0;
      else if (win_open)      seen <= got;
      if (close) begin
        arrived <= got;
        idle    <= ~got;
      end
      err <= (err & ~err_clr) | bad;
    end
  end

  p_offset_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_start && offset == '0) |=> int_start);

  p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_start && offset != '0) |=> !int_start);

  p_win_with_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    int_start |-> win_open);

  p_outside_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((soc_in != '0) && !win_open) |=> ((err & $past(soc_in)) == $past(soc_in)));

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(err) & ~$past(err_clr) & ~err) == '0));

  p_flags_disjoint_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (arrived & idle) == '0);
endmodule

// File: tb/test_cell_window_chk.sv
module test_cell_window_chk;
  localparam int N = 8;
  logic clk = 1'b0, rst_n = 1'b0, ext_start = 1'b0;
  logic [7:0] offset = '0;
  logic [N-1:0] soc_in = '0, err_clr = '0;
  logic int_start, win_open;
  logic [N-1:0] arrived, idle, err;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  cell_window_chk i_cell_window_chk (
    .clk(clk), .rst_n(rst_n), .ext_start(ext_start), .offset(offset),
    .soc_in(soc_in), .err_clr(err_clr), .int_start(int_start),
    .win_open(win_open), .arrived(arrived), .idle(idle), .err(err));

  task automatic tick(); @(negedge clk); endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // pulse ext_start, return in the cycle int_start should be high
  task automatic launch(int off);
    offset = 8'(off);
    ext_start = 1'b1; tick(); ext_start = 1'b0;
    for (int i = 0; i < off; i++) begin
      check("R1 no early int_start", int_start, 0);
      tick();
    end
    check(off == 0 ? "R2 int_start at offset zero" : "R1 int_start delay", int_start, 1);
  endtask

  // run the 8 window cycles with strobes in cycles c1/c2
  task automatic window(int c1, logic [N-1:0] m1, int c2, logic [N-1:0] m2);
    for (int i = 1; i <= 8; i++) begin
      check("R4 win_open inside", win_open, 1);
      if (i == 2) check("R1 int_start single pulse", int_start, 0);
      soc_in = (i == c1 ? m1 : '0) | (i == c2 ? m2 : '0);
      tick();
    end
    soc_in = '0;
    check("R4 win_open closed after 8", win_open, 0);
  endtask

  task automatic t_reset();
    check("R10 reset int_start", int_start, 0);
    check("R10 reset win_open", win_open, 0);
    check("R10 reset arrived", arrived, 0);
    check("R10 reset idle", idle, 0);
    check("R10 reset err", err, 0);
  endtask

  task automatic t_arrival();
    launch(3);
    window(1, 8'h05, 5, 8'h10);
    check("R5 arrived", arrived, 8'h15);
    check("R8 idle", idle, 8'hEA);
    check("R5 no err", err, 0);
    for (int i = 0; i < 4; i++) tick();
    check("R10 arrived holds", arrived, 8'h15);
    check("R10 idle holds", idle, 8'hEA);
  endtask

  task automatic t_offset_zero();
    launch(0);
    window(8, 8'h80, 0, '0);
    check("R5 arrived last cycle", arrived, 8'h80);
    check("R8 idle rest", idle, 8'h7F);
    check("R5 no err last cycle", err, 0);
  endtask

  task automatic t_outside();
    soc_in = 8'h40; tick(); soc_in = '0;
    check("R6 err outside window", err, 8'h40);
    tick();
    check("R9 err sticky", err, 8'h40);
    err_clr = 8'h40; soc_in = 8'h40; tick(); err_clr = '0; soc_in = '0;
    check("R9 set wins over clear", err, 8'h40);
    err_clr = 8'h40; tick(); err_clr = '0;
    check("R9 cleared", err, 0);
  endtask

  task automatic t_double();
    launch(1);
    window(2, 8'h02, 6, 8'h02);
    check("R7 double err", err, 8'h02);
    check("R7 still arrived", arrived, 8'h02);
    check("R8 idle others", idle, 8'hFD);
    err_clr = '1; tick(); err_clr = '0;
    check("R9 clear all", err, 0);
  endtask

  task automatic t_restart();
    offset = 8'd5;
    ext_start = 1'b1; tick(); ext_start = 1'b0;
    tick(); tick();
    launch(5);
    tick();
    check("R1 single pulse after restart", int_start, 0);
    for (int i = 0; i < 7; i++) tick();
    check("R3 window closed, no second start", win_open, 0);
    for (int i = 0; i < 4; i++) begin
      check("R3 no stale int_start", int_start, 0);
      tick();
    end
    check("R8 silent window idle", idle, 8'hFF);
    check("R8 silent window not arrived", arrived, 0);
    check("R8 silent no err", err, 0);
  endtask

  initial begin
    tick(); tick();
    t_reset();
    rst_n = 1'b1; tick();
    t_reset();
    t_arrival();
    t_offset_zero();
    t_outside();
    t_double();
    t_restart();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule